// File: doc/BRIEF.md
# ATM receive cell dispatcher

The dispatcher sits behind the receive side of an ATM port. Incoming cells enter a 32-deep input queue. For the cell at the head of the queue, the block searches a 16-entry table of virtual circuits, keyed on VPI and VCI. It also classes the cell as OAM or user traffic from the PTI bits. The cell is then handed to the payload (SAR) output, to the host data-cell output, to both, or to neither. Each output has its own valid/ready handshake.

Known circuits carry three routing flags: send user cells to SAR, send user cells to the host, and send OAM cells to the host. OAM cells never go to the SAR path. Cells whose circuit is not in the table follow two global enables, one for OAM cells and one for user cells. Such cells can only reach the host output. A cell that has no enabled destination is dropped, and a counter for its class (OAM or user) is incremented.

A cell word is packed as `{vpi[7:0], vci[15:0], pti[2:0], tag[7:0]}`. The PTI field therefore sits at bits 10:8, and the tag is an opaque handle to the stored payload. Each output carries a copy of the head cell word.

Top module: `atm_rx_dispatch`

## Requirements
- R1: The input queue holds up to 32 cells. `inReady` is low exactly when 32 cells are held. Cells leave the queue in arrival order.
- R2: A cell is OAM when its PTI field is 3'b100 or 3'b101. Every other PTI value, including 3'b110 and 3'b111, is a user cell.
- R3: A user cell that hits a table entry whose SAR flag is set is presented on the SAR output with its cell word unchanged.
- R4: A user cell that hits an entry whose user-to-host flag is set is presented on the host output. When both that flag and the SAR flag are set, the cell appears on both outputs.
- R5: An OAM cell that hits an entry goes to the host output exactly when that entry's OAM-to-host flag is set. An OAM cell is never presented on the SAR output.
- R6: A cell that misses the table goes to the host output if it is OAM and `unkOamHost` is 1, or if it is user and `unkUserHost` is 1. Otherwise it is dropped. A missed cell never reaches the SAR output.
- R7: Each output holds its valid and cell word until it accepts the cell, then deasserts valid for that cell. The cell is dequeued only after every selected output has accepted it, and a stalled output stalls the queue.
- R8: A cell with no destination is dequeued in one cycle without raising either valid. This increments `dropOamCnt` (OAM) or `dropUserCnt` (user) by one.
- R9: A configuration write with `cfgValid`=1 installs or replaces an entry, and one with `cfgValid`=0 removes it. When two valid entries match, the lowest index decides.
- R10: After reset the queue is empty, all table entries are invalid, both counters are zero, and both valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input cell present |
| inReady | output | 1 | Queue can accept a cell |
| inCell | input | 35 | Input cell word |
| sarValid | output | 1 | Cell offered to the SAR path |
| sarReady | input | 1 | SAR path accepts |
| sarCell | output | 35 | Cell word toward SAR |
| hostValid | output | 1 | Cell offered to the host data-cell FIFO |
| hostReady | input | 1 | Host FIFO accepts |
| hostCell | output | 35 | Cell word toward host |
| cfgWe | input | 1 | Table write strobe |
| cfgIdx | input | 4 | Table entry index |
| cfgValid | input | 1 | Entry valid bit to write |
| cfgVpi | input | 8 | Entry VPI |
| cfgVci | input | 16 | Entry VCI |
| cfgSar | input | 1 | Entry flag: user cells to SAR |
| cfgOamHost | input | 1 | Entry flag: OAM cells to host |
| cfgUserHost | input | 1 | Entry flag: user cells to host |
| unkOamHost | input | 1 | Global enable: missed OAM cells to host |
| unkUserHost | input | 1 | Global enable: missed user cells to host |
| dropOamCnt | output | 16 | Dropped OAM cell count |
| dropUserCnt | output | 16 | Dropped user cell count |

## Verification
The hold-until-accepted checks assume that the table and the two global enables stay constant while a cell sits at the head of the queue, because the route is recomputed every cycle. The bench therefore writes the table and changes the enables only when the queue is empty and both valids are low. It also applies outputs' ready signals freely, including a split stall where the SAR output accepts while the host output is held off.

// File: rtl/rxdisp_pkg.sv
package rxdisp_pkg;

  typedef struct packed {
    logic pop;
    logic dropOam;
    logic dropUser;
  } dispStrobe_t;

  function automatic logic ptiIsOam(input logic [2:0] pti);
    return pti[2] && !pti[1];
  endfunction

endpackage

// File: rtl/rxdisp_dp.sv
module rxdisp_dp
  import rxdisp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int VC_N   = 16,
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16,
  localparam int CELL_W = VPI_W + VCI_W + 3 + TAG_W,
  localparam int IW     = $clog2(VC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CELL_W-1:0] inCell,
  input  logic              cfgWe,
  input  logic [IW-1:0]     cfgIdx,
  input  logic              cfgValid,
  input  logic [VPI_W-1:0]  cfgVpi,
  input  logic [VCI_W-1:0]  cfgVci,
  input  logic              cfgSar,
  input  logic              cfgOamHost,
  input  logic              cfgUserHost,
  input  dispStrobe_t       strb,
  output logic              headValid,
  output logic [CELL_W-1:0] headCell,
  output logic              hit,
  output logic              hitSar,
  output logic              hitOamHost,
  output logic              hitUserHost,
  output logic [CNT_W-1:0]  dropOamCnt,
  output logic [CNT_W-1:0]  dropUserCnt
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // ---------------- input queue ----------------
  logic [CELL_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic              doPush;

  assign inReady   = (count != FULL_CNT);
  assign doPush    = inValid && inReady;
  assign headValid = (count != '0);
  assign headCell  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= inCell;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.pop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(strb.pop);
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> headValid);

  // ---------------- circuit table ----------------
  logic             entValid [VC_N];
  logic [VPI_W-1:0] entVpi   [VC_N];
  logic [VCI_W-1:0] entVci   [VC_N];
  logic             entSar   [VC_N];
  logic             entOam   [VC_N];
  logic             entUser  [VC_N];

  wire [VPI_W-1:0] headVpi = headCell[CELL_W-1 -: VPI_W];
  wire [VCI_W-1:0] headVci = headCell[CELL_W-VPI_W-1 -: VCI_W];

  for (genvar i = 0; i < VC_N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entVpi[i]   <= '0;
        entVci[i]   <= '0;
        entSar[i]   <= 1'b0;
        entOam[i]   <= 1'b0;
        entUser[i]  <= 1'b0;
      end else if (cfgWe && cfgIdx == IW'(i)) begin
        entValid[i] <= cfgValid;
        entVpi[i]   <= cfgVpi;
        entVci[i]   <= cfgVci;
        entSar[i]   <= cfgSar;
        entOam[i]   <= cfgOamHost;
        entUser[i]  <= cfgUserHost;
      end
    end
  end

  // lowest matching index wins: scan downward so it is assigned last
  always_comb begin
    hit         = 1'b0;
    hitSar      = 1'b0;
    hitOamHost  = 1'b0;
    hitUserHost = 1'b0;
    for (int i = VC_N - 1; i >= 0; i--) begin
      if (entValid[i] && entVpi[i] == headVpi && entVci[i] == headVci) begin
        hit         = 1'b1;
        hitSar      = entSar[i];
        hitOamHost  = entOam[i];
        hitUserHost = entUser[i];
      end
    end
  end

  // ---------------- discard counters ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dropOamCnt  <= '0;
      dropUserCnt <= '0;
    end else begin
      if (strb.dropOam)  dropOamCnt  <= dropOamCnt + 1'b1;
      if (strb.dropUser) dropUserCnt <= dropUserCnt + 1'b1;
    end
  end

  p_drop_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.dropOam && strb.dropUser));

endmodule

// File: rtl/rxdisp_ctrl.sv
module rxdisp_ctrl
  import rxdisp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        headValid,
  input  logic [2:0]  headPti,
  input  logic        hit,
  input  logic        hitSar,
  input  logic        hitOamHost,
  input  logic        hitUserHost,
  input  logic        unkOamHost,
  input  logic        unkUserHost,
  output logic        sarValid,
  input  logic        sarReady,
  output logic        hostValid,
  input  logic        hostReady,
  output dispStrobe_t strb
);

  logic isOam, sarNeed, hostNeed, sarOk, hostOk;
  logic sarDone, hostDone;

  always_comb begin
    isOam    = ptiIsOam(headPti);
    sarNeed  = headValid && hit && !isOam && hitSar;
    if (hit)
      hostNeed = headValid && (isOam ? hitOamHost : hitUserHost);
    else
      hostNeed = headValid && (isOam ? unkOamHost : unkUserHost);

    sarValid  = sarNeed && !sarDone;
    hostValid = hostNeed && !hostDone;
    sarOk     = !sarNeed || sarDone || sarReady;
    hostOk    = !hostNeed || hostDone || hostReady;

    strb.pop      = headValid && sarOk && hostOk;
    strb.dropOam  = strb.pop && !sarNeed && !hostNeed && isOam;
    strb.dropUser = strb.pop && !sarNeed && !hostNeed && !isOam;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarDone  <= 1'b0;
      hostDone <= 1'b0;
    end else if (strb.pop) begin
      sarDone  <= 1'b0;
      hostDone <= 1'b0;
    end else begin
      if (sarValid && sarReady)   sarDone  <= 1'b1;
      if (hostValid && hostReady) hostDone <= 1'b1;
    end
  end

  p_oam_not_sar_r5: assert property (@(posedge clk) disable iff (!rstN)
    sarValid |-> !(headPti[2] && !headPti[1]));
  p_unknown_not_sar_r6: assert property (@(posedge clk) disable iff (!rstN)
    sarValid |-> hit);
  p_sar_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    sarValid && !sarReady |=> sarValid);
  p_host_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !hostReady |=> hostValid);
  p_drop_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dropOam || strb.dropUser) |-> !sarValid && !hostValid);

endmodule

// File: rtl/atm_rx_dispatch.sv
module atm_rx_dispatch
  import rxdisp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int VC_N   = 16,
  parameter int VPI_W  = 8,
  parameter int VCI_W  = 16,
  parameter int TAG_W  = 8,
  parameter int CNT_W  = 16,
  localparam int CELL_W = VPI_W + VCI_W + 3 + TAG_W,
  localparam int IW     = $clog2(VC_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CELL_W-1:0] inCell,
  output logic              sarValid,
  input  logic              sarReady,
  output logic [CELL_W-1:0] sarCell,
  output logic              hostValid,
  input  logic              hostReady,
  output logic [CELL_W-1:0] hostCell,
  input  logic              cfgWe,
  input  logic [IW-1:0]     cfgIdx,
  input  logic              cfgValid,
  input  logic [VPI_W-1:0]  cfgVpi,
  input  logic [VCI_W-1:0]  cfgVci,
  input  logic              cfgSar,
  input  logic              cfgOamHost,
  input  logic              cfgUserHost,
  input  logic              unkOamHost,
  input  logic              unkUserHost,
  output logic [CNT_W-1:0]  dropOamCnt,
  output logic [CNT_W-1:0]  dropUserCnt
);

  dispStrobe_t       strb;
  logic              headValid, hit, hitSar, hitOamHost, hitUserHost;
  logic [CELL_W-1:0] headCell;

  rxdisp_dp #(
    .DEPTH(DEPTH), .VC_N(VC_N), .VPI_W(VPI_W), .VCI_W(VCI_W),
    .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk, .rstN, .inValid, .inReady, .inCell,
    .cfgWe, .cfgIdx, .cfgValid, .cfgVpi, .cfgVci,
    .cfgSar, .cfgOamHost, .cfgUserHost,
    .strb, .headValid, .headCell,
    .hit, .hitSar, .hitOamHost, .hitUserHost,
    .dropOamCnt, .dropUserCnt
  );

  rxdisp_ctrl u_ctrl (
    .clk, .rstN, .headValid,
    .headPti(headCell[TAG_W+2:TAG_W]),
    .hit, .hitSar, .hitOamHost, .hitUserHost,
    .unkOamHost, .unkUserHost,
    .sarValid, .sarReady, .hostValid, .hostReady,
    .strb
  );

  assign sarCell  = headCell;
  assign hostCell = headCell;

  p_sar_word_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    sarValid && !sarReady |=> $stable(sarCell));
  p_host_word_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    hostValid && !hostReady |=> $stable(hostCell));

endmodule

// File: tb/atm_rx_dispatch_test.sv
`timescale 1ns/1ps
module atm_rx_dispatch_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inReady;
  logic [34:0] inCell = '0;
  logic        sarValid, sarReady = 1'b1;
  logic [34:0] sarCell;
  logic        hostValid, hostReady = 1'b1;
  logic [34:0] hostCell;
  logic        cfgWe = 1'b0, cfgValid = 1'b0;
  logic [3:0]  cfgIdx = '0;
  logic [7:0]  cfgVpi = '0;
  logic [15:0] cfgVci = '0;
  logic        cfgSar = 1'b0, cfgOamHost = 1'b0, cfgUserHost = 1'b0;
  logic        unkOamHost = 1'b1, unkUserHost = 1'b0;
  logic [15:0] dropOamCnt, dropUserCnt;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  atm_rx_dispatch uut (.*);

  // vector: {vpi, vci, pti, tag, expSar, expHost}
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {8'd1, 16'd100, 3'b000, 8'h01, 1'b1, 1'b0},  // R3
    {8'd1, 16'd100, 3'b100, 8'h02, 1'b0, 1'b0},  // R5 drop oam
    {8'd1, 16'd101, 3'b001, 8'h03, 1'b1, 1'b1},  // R4 both
    {8'd1, 16'd101, 3'b101, 8'h04, 1'b0, 1'b1},  // R5
    {8'd1, 16'd101, 3'b110, 8'h05, 1'b1, 1'b1},  // R2 user
    {8'd1, 16'd101, 3'b111, 8'h06, 1'b1, 1'b1},  // R2 user
    {8'd2, 16'd200, 3'b000, 8'h07, 1'b0, 1'b1},  // R4
    {8'd2, 16'd200, 3'b100, 8'h08, 1'b0, 1'b0},  // R8 drop oam
    {8'd3, 16'd300, 3'b010, 8'h09, 1'b0, 1'b0},  // R8 drop user
    {8'd9, 16'd999, 3'b100, 8'h0A, 1'b0, 1'b1},  // R6
    {8'd9, 16'd999, 3'b000, 8'h0B, 1'b0, 1'b0},  // R6 drop user
    {8'd1, 16'd100, 3'b010, 8'h0C, 1'b1, 1'b0}   // R3
  };

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [3:0] idx, input logic v, input logic [7:0] vpi,
                            input logic [15:0] vci, input logic s, input logic o,
                            input logic u);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgValid = v; cfgVpi = vpi; cfgVci = vci;
    cfgSar = s; cfgOamHost = o; cfgUserHost = u;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // pushes one cell; returns at the negedge where it is at the head
  task automatic pushCell(input logic [34:0] c);
    @(negedge clk);
    inValid = 1'b1; inCell = c;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(inReady == 1'b1, "R10", inReady, 1);
    check(!sarValid && !hostValid, "R10", {sarValid, hostValid}, 0);
    check(dropOamCnt == 0 && dropUserCnt == 0, "R10", {dropOamCnt, dropUserCnt}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sarValid && !hostValid && inReady, "R10", {sarValid, hostValid, inReady}, 1);

    writeEntry(4'd0, 1'b1, 8'd1, 16'd100, 1'b1, 1'b0, 1'b0);
    writeEntry(4'd1, 1'b1, 8'd1, 16'd101, 1'b1, 1'b1, 1'b1);
    writeEntry(4'd2, 1'b1, 8'd2, 16'd200, 1'b0, 1'b0, 1'b1);
    writeEntry(4'd3, 1'b1, 8'd3, 16'd300, 1'b0, 1'b0, 1'b0);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [34:0] c;
      logic        es, eh;
      c  = VEC[i][36:2];
      es = VEC[i][1];
      eh = VEC[i][0];
      pushCell(c);
      check(sarValid == es, "R3/R5 sar route", sarValid, es);
      check(hostValid == eh, "R4/R6 host route", hostValid, eh);
      if (es) check(sarCell == c, "R3 sar word", sarCell, c);
      if (eh) check(hostCell == c, "R4 host word", hostCell, c);
      @(negedge clk);
      check(!sarValid && !hostValid, "R7 dequeued", {sarValid, hostValid}, 0);
    end
    // R8 counters: two OAM drops, two user drops
    check(dropOamCnt == 16'd2, "R8 oam drops", dropOamCnt, 2);
    check(dropUserCnt == 16'd2, "R8 user drops", dropUserCnt, 2);

    // R6 swapped global enables
    unkOamHost = 1'b0; unkUserHost = 1'b1;
    pushCell({8'd9, 16'd999, 3'b001, 8'h20});
    check(hostValid && !sarValid, "R6 unknown user to host", {sarValid, hostValid}, 1);
    @(negedge clk);
    pushCell({8'd9, 16'd999, 3'b101, 8'h21});
    check(!hostValid && !sarValid, "R6 unknown oam dropped", {sarValid, hostValid}, 0);
    @(negedge clk);
    check(dropOamCnt == 16'd3, "R8 oam drops", dropOamCnt, 3);
    check(dropUserCnt == 16'd2, "R6 user count untouched", dropUserCnt, 2);

    // R7 split stall on a dual-route cell
    hostReady = 1'b0;
    pushCell({8'd1, 16'd101, 3'b000, 8'h30});
    check(sarValid && hostValid, "R7 both offered", {sarValid, hostValid}, 3);
    @(negedge clk);
    check(!sarValid && hostValid, "R7 sar taken host waits", {sarValid, hostValid}, 1);
    @(negedge clk);
    check(hostValid && hostCell[7:0] == 8'h30, "R7 host holds", hostCell[7:0], 8'h30);
    hostReady = 1'b1;
    @(negedge clk);
    check(!sarValid && !hostValid, "R7 dequeued after both", {sarValid, hostValid}, 0);

    // R7 host stall blocks the next cell
    hostReady = 1'b0;
    pushCell({8'd1, 16'd101, 3'b000, 8'h31});
    pushCell({8'd1, 16'd100, 3'b000, 8'h32});
    check(!sarValid && hostCell[7:0] == 8'h31, "R7 queue stalled", hostCell[7:0], 8'h31);
    hostReady = 1'b1;
    @(negedge clk);
    check(sarValid && !hostValid && sarCell[7:0] == 8'h32, "R7 next cell after release",
          sarCell[7:0], 8'h32);
    @(negedge clk);

    // R1 fill to 32 with unknown user cells held at the host output
    hostReady = 1'b0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (!inReady) begin
        check(1'b0, "R1 ready while filling", k, 32);
      end
      inValid = 1'b1; inCell = {8'd9, 16'd999, 3'b000, 8'(k)};
    end
    @(negedge clk);
    inCell = {8'd9, 16'd999, 3'b000, 8'h99};
    check(inReady == 1'b0, "R1 full", inReady, 0);
    @(negedge clk);
    inValid = 1'b0;
    hostReady = 1'b1;
    for (int k = 0; k < 32; k++) begin
      check(hostValid && hostCell[7:0] == 8'(k), "R1 order", hostCell[7:0], k);
      @(negedge clk);
    end
    check(!hostValid && inReady, "R1 overflow cell refused", {hostValid, inReady}, 1);

    // R9 remove entry, then duplicate priority
    writeEntry(4'd0, 1'b0, 8'd1, 16'd100, 1'b1, 1'b0, 1'b0);
    pushCell({8'd1, 16'd100, 3'b000, 8'h40});
    check(!sarValid && hostValid, "R9 removed entry misses", {sarValid, hostValid}, 1);
    @(negedge clk);
    writeEntry(4'd5, 1'b1, 8'd2, 16'd200, 1'b1, 1'b0, 1'b0);
    pushCell({8'd2, 16'd200, 3'b000, 8'h41});
    check(!sarValid && hostValid, "R9 lowest index wins", {sarValid, hostValid}, 1);
    @(negedge clk);
    writeEntry(4'd2, 1'b0, 8'd2, 16'd200, 1'b0, 1'b0, 1'b1);
    pushCell({8'd2, 16'd200, 3'b000, 8'h42});
    check(sarValid && !hostValid, "R9 higher entry after removal", {sarValid, hostValid}, 2);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule